// File: doc/BRIEF.md
# Dither-Correlating Inter-Stage Gain Reciprocal Tracker

This block keeps a running estimate of the reciprocal of a pipeline converter's inter-stage gain. The estimate starts at 0.25, which is the reciprocal of the nominal gain of four. For each sample, the block takes two inputs: the residue word `x`, which is the converter output minus the first-stage code, and the one-bit dither sign that was used to shift the sub-converter thresholds for that sample. The dither is zero-mean and does not depend on the signal. Because of that, multiplying the residue by the dither sign removes the signal term on average. What remains is proportional to the error in the current estimate. The block adds `sign·x` to an accumulator each time a sample is flagged valid, after scaling it by a power-of-two step.

The step is `2^-mu_shift`, where `mu_shift` runs from 0 to 15. A small shift converges quickly and tracks drift well, but leaves more steady-state jitter. A large shift averages longer and settles more finely. The accumulator carries guard bits below the published precision, so that small steps still build up over many samples. The surrounding correction logic reads the upper bits of the accumulator as the reciprocal gain. A freeze input holds the estimate where it is, for example while the dither is paused.

Top module: `gest_core`

## Requirements
- R1: A synchronous reset loads the accumulator with 0.25. The accumulator has 30 fraction bits, so the output `gain_recip` (24 bits, 22 fraction bits) reads 1048576 on the first cycle after reset is released.
- R2: When `smp_valid`=1, `freeze`=0 and `dither_pos`=1 (dither sign +1), the accumulator adds the residue. The residue has 14 fraction bits and is aligned to 30 fraction bits (a shift left by 16) before the add. The new value shows at the output after the next rising edge.
- R3: When `dither_pos`=0 (dither sign −1) with the same qualifiers, the accumulator subtracts the aligned residue instead.
- R4: The signed increment is shifted right arithmetically by `mu_shift` (0..15) before it is added. This is a floor division by 2^mu_shift.
- R5: When `smp_valid`=0, the accumulator and the output stay unchanged, whatever values `residue`, `dither_pos` and `mu_shift` carry.
- R6: When `freeze`=1, the accumulator and the output stay unchanged even if `smp_valid`=1. The held value is kept, and updates resume from it once `freeze` returns to 0.
- R7: The accumulator saturates at 2^31−1 and −2^31 and never wraps. The output therefore pins at 8388607 and −8388608.
- R8: `gain_recip` is accumulator bits [31:8]. The 8 low guard bits collect sub-LSB steps without changing the output until a carry reaches bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Residue and dither of this cycle form a sample |
| dither_pos | input | 1 | Dither sign: 1 = +1, 0 = −1 |
| residue | input | 16 | Signed residue x, 14 fraction bits |
| mu_shift | input | 4 | Step size exponent, step = 2^-mu_shift |
| freeze | input | 1 | Hold the estimate |
| gain_recip | output | 24 | Signed reciprocal gain estimate, 22 fraction bits |

## Verification
The assertions assume that `residue`, `dither_pos`, `mu_shift` and `freeze` are settled at every rising edge. They also assume that a sample whose sign and residue agree always moves the estimate in one direction, so only the saturation limit can stop it. The stimulus changes inputs only on falling edges. It sweeps every shift value against both dither signs and against residues that include the most negative and most positive codes, so each update hits the alignment and negation extremes. Runs of same-sign full-scale samples drive the accumulator into both rails.

// File: rtl/gest_pkg.sv
package gest_pkg;

    // Width of the step-size exponent field.
    localparam int SHIFT_W = 4;

    // Encoding of the dither sign bit.
    typedef enum logic {
        DITHER_NEG = 1'b0,
        DITHER_POS = 1'b1
    } dither_e;

endpackage

// File: rtl/gest_step.sv
module gest_step
    import gest_pkg::*;
#(
    parameter int XW    = 16,
    parameter int XF    = 14,
    parameter int ACC_W = 32,
    parameter int ACC_F = 30
) (
    input  logic                     dither_pos,
    input  logic [XW-1:0]            residue,
    input  logic [SHIFT_W-1:0]       mu_shift,
    output logic signed [ACC_W:0]    step
);
    // One extra bit lets the negated most-negative residue fit.
    localparam int EW    = ACC_W + 1;
    localparam int ALIGN = ACC_F - XF;

    logic signed [EW-1:0] aligned_w;
    logic signed [EW-1:0] signed_w;

    always_comb begin
        aligned_w = {{(EW-XW){residue[XW-1]}}, residue} <<< ALIGN;
        // Dither of +/-1 reduces the multiply to a conditional negation.
        signed_w  = (dither_e'(dither_pos) == DITHER_POS) ? aligned_w : -aligned_w;
        step      = signed_w >>> mu_shift;
    end

    // R4: shifting keeps the sign of the product (floor toward minus infinity).
    always_comb begin
        if (dither_pos && !residue[XW-1])
            p_step_sign_r4: assert (!step[ACC_W]);
        if (!dither_pos && !residue[XW-1] && residue != '0)
            p_step_neg_r4: assert (step[ACC_W]);
    end

endmodule

// File: rtl/gest_satadd.sv
module gest_satadd #(
    parameter int W = 32
) (
    input  logic signed [W-1:0] acc,
    input  logic signed [W:0]   inc,
    output logic signed [W-1:0] sum
);
    localparam logic signed [W+1:0] MAXV = {3'b000, {(W-1){1'b1}}};
    localparam logic signed [W+1:0] MINV = {3'b111, {(W-1){1'b0}}};

    logic signed [W+1:0] wide_w;

    always_comb begin
        wide_w = {acc[W-1], acc[W-1], acc} + {inc[W], inc};
        if (wide_w > MAXV)
            sum = MAXV[W-1:0];
        else if (wide_w < MINV)
            sum = MINV[W-1:0];
        else
            sum = wide_w[W-1:0];
    end

    // R7: a non-negative increment never lowers the sum, a negative never raises it.
    always_comb begin
        if (!inc[W]) p_sat_up_r7: assert (sum >= acc);
        else         p_sat_dn_r7: assert (sum <= acc);
    end

endmodule

// File: rtl/gest_core.sv
module gest_core
    import gest_pkg::*;
#(
    parameter int XW    = 16,
    parameter int XF    = 14,
    parameter int ACC_W = 32,
    parameter int GUARD = 8,
    parameter int ACC_F = 30,
    localparam int OW   = ACC_W - GUARD
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic                dither_pos,
    input  logic [XW-1:0]       residue,
    input  logic [SHIFT_W-1:0]  mu_shift,
    input  logic                freeze,
    output logic [OW-1:0]       gain_recip
);
    // Reciprocal of the nominal gain of four: 0.25.
    localparam logic [ACC_W-1:0] NOMINAL = {{(ACC_W-1){1'b0}}, 1'b1} << (ACC_F - 2);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } state_t;

    state_t st_d, st_q;

    logic signed [ACC_W:0]   step_w;
    logic signed [ACC_W-1:0] sum_w;

    gest_step #(.XW(XW), .XF(XF), .ACC_W(ACC_W), .ACC_F(ACC_F)) u_step (
        .dither_pos (dither_pos),
        .residue    (residue),
        .mu_shift   (mu_shift),
        .step       (step_w)
    );

    gest_satadd #(.W(ACC_W)) u_add (
        .acc (signed'(st_q.acc)),
        .inc (step_w),
        .sum (sum_w)
    );

    always_comb begin
        st_d = st_q;
        if (rst)
            st_d.acc = NOMINAL;
        else if (smp_valid && !freeze)
            st_d.acc = sum_w;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign gain_recip = st_q.acc[ACC_W-1:GUARD];

    // R1: first cycle after reset shows the nominal value.
    p_reset_value_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> st_q.acc == NOMINAL);

    // R5: no sample, no movement.
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(st_q.acc));

    // R6: freeze holds the estimate.
    p_hold_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        freeze |=> $stable(gain_recip));

    // R2: positive dither with non-negative residue never lowers the estimate.
    p_dir_up_r2: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !freeze && dither_pos && !residue[XW-1])
        |=> signed'(st_q.acc) >= signed'($past(st_q.acc)));

    // R3: negative dither with non-negative residue never raises the estimate.
    p_dir_down_r3: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !freeze && !dither_pos && !residue[XW-1])
        |=> signed'(st_q.acc) <= signed'($past(st_q.acc)));

endmodule

// File: tb/sim_gest_core.sv
module sim_gest_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic        dither_pos = 1'b0;
    logic [15:0] residue = '0;
    logic [3:0]  mu_shift = '0;
    logic        freeze = 1'b0;
    logic [23:0] gain_recip;

    int     n_checks = 0;
    int     n_errors = 0;
    bit     done = 1'b0;
    longint model = 0;

    localparam longint ACC_MAX = 64'sd2147483647;
    localparam longint ACC_MIN = -64'sd2147483648;

    always #2 clk = ~clk;

    gest_core u0 (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .dither_pos (dither_pos),
        .residue    (residue),
        .mu_shift   (mu_shift),
        .freeze     (freeze),
        .gain_recip (gain_recip)
    );

    function automatic longint expected_out(longint acc);
        return acc >>> 8;
    endfunction

    task automatic check_out(string req);
        longint act;
        longint exp;
        act = longint'($signed(gain_recip));
        exp = expected_out(model);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: gain_recip=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, update the model at the rising edge,
    // then check at the next falling edge.
    task automatic cycle(input bit v, input bit d, input int x, input int sh,
                         input bit fz, input string req);
        longint t;
        smp_valid  = v;
        dither_pos = d;
        residue    = 16'(x);
        mu_shift   = 4'(sh);
        freeze     = fz;
        @(posedge clk);
        if (v && !fz) begin
            t = longint'(x) * 65536;
            if (!d) t = -t;
            t = t >>> sh;
            model = model + t;
            if (model > ACC_MAX) model = ACC_MAX;
            if (model < ACC_MIN) model = ACC_MIN;
        end
        @(negedge clk);
        check_out(req);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        smp_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model = 64'sd268435456;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: run did not finish");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int xs[6];
        xs = '{1, -1, 12345, -32768, 32767, 7};
        @(negedge clk);
        do_reset();
        // R1: nominal 0.25 -> 1048576
        check_out("R1");

        // R2/R3/R4 sweep over every shift, both signs, edge residues
        for (int sh = 0; sh < 16; sh++) begin
            for (int d = 0; d < 2; d++) begin
                for (int i = 0; i < 6; i++) begin
                    cycle(1'b1, d[0], xs[i], sh, 1'b0, d[0] ? "R2/R4" : "R3/R4");
                end
            end
        end

        // R5: valid low with busy inputs
        for (int i = 0; i < 6; i++)
            cycle(1'b0, i[0], xs[i], i, 1'b0, "R5");

        // R6: freeze with valid high, then resume
        for (int i = 0; i < 6; i++)
            cycle(1'b1, 1'b1, 32767, 0, 1'b1, "R6");
        cycle(1'b1, 1'b0, 1000, 2, 1'b0, "R6");

        // R8: sub-LSB step stays in guard bits
        do_reset();
        cycle(1'b1, 1'b1, 1, 15, 1'b0, "R8");
        for (int i = 0; i < 127; i++)
            cycle(1'b1, 1'b1, 1, 15, 1'b0, "R8");

        // R7: drive both rails
        for (int i = 0; i < 4; i++)
            cycle(1'b1, 1'b1, 32767, 0, 1'b0, "R7");
        n_checks++;
        if ($signed(gain_recip) != 24'sd8388607) begin
            n_errors++;
            $display("FAIL R7: gain_recip=%0d expected=8388607", $signed(gain_recip));
        end
        for (int i = 0; i < 6; i++)
            cycle(1'b1, 1'b0, 32767, 0, 1'b0, "R7");
        n_checks++;
        if ($signed(gain_recip) != -24'sd8388608) begin
            n_errors++;
            $display("FAIL R7: gain_recip=%0d expected=-8388608", $signed(gain_recip));
        end
        cycle(1'b1, 1'b1, -32768, 0, 1'b0, "R7");

        // R1: reset in mid-run restores nominal
        do_reset();
        check_out("R1");

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule